// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block turns single-byte requests from a host into timed chip-select, read-strobe and write-strobe waveforms for an 8-bit asynchronous memory or NAND flash device. Every access runs through three timed phases: setup, strobe and hold. Chip-select stays low across all three phases. The read or write strobe is low only in the strobe phase.

All phase lengths come from one 32-bit timing word. That word holds separate setup, strobe and hold counts for writes and for reads, plus a turnaround count. The turnaround cycles are inserted only when an access changes direction from the one before it. The host marks each byte as a command byte, an address byte or plain data through two select bits. These two bits drive the device's command-latch and address-latch lines for the whole access.

The host holds a request until it sees a one-cycle acknowledge. A read returns the byte captured on the final strobe cycle. A registered copy of the device's ready pin is available to the host as a status byte.

Top module: `amem_strobe_seq`

## Requirements
- R1: While reset is high and after it falls, every strobe is inactive: chip-select, read strobe and write strobe are high. The acknowledge, both latch lines and the data output enable are low. Reset is synchronous and active high.
- R2: A write uses the timing-word fields [29:26] for setup, [25:20] for strobe and [19:17] for hold. Each phase lasts its field value plus one clock. The write strobe is low only in the strobe phase, and chip-select is low across all three phases.
- R3: A read uses the timing-word fields [16:13] for setup, [12:7] for strobe and [6:4] for hold. Each phase lasts its field value plus one clock. The read strobe is low only in the strobe phase, and chip-select is low across all three phases.
- R4: When an access has the opposite direction to the previous access, chip-select stays high for (field [3:2] + 1) extra clocks before setup begins. Same-direction accesses, and the first access after reset, start setup on the clock after the request is seen.
- R5: While chip-select is low, the command-latch line equals host select bit 0 and the address-latch line equals host select bit 1. Both lines are low whenever chip-select is high.
- R6: During a write, the data output enable is high and the write byte is driven for the whole time chip-select is low. During reads and between accesses, the output enable is low.
- R7: The read byte returned to the host is the device data present in the last strobe-phase clock of the read.
- R8: The acknowledge is a single-cycle pulse in the clock after the last hold cycle. Chip-select is already high in that cycle.
- R9: The timing word is sampled when an access starts. Changing it while the access is running does not alter that access's phase lengths.
- R10: Status bit 0 shows the device ready input one clock later. Status bits 7:1 read as zero.
- R11: No access starts while timing-word bit 31, bit 30 or bus-size field [1:0] is nonzero, because only the plain 8-bit mode is supported. The request stays pending with every strobe high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Bit 0 = command latch, bit 1 = address latch |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| host_stat | output | 8 | Status, bit 0 = device ready |
| cfg_word | input | 32 | Packed phase timing word |
| mem_cs_n | output | 1 | Device chip-select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cle | output | 1 | Command-latch enable |
| mem_ale | output | 1 | Address-latch enable |
| mem_dq_out | output | 8 | Byte driven toward the device |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte returned by the device |
| mem_rdy | input | 1 | Device ready |

## Verification
The assertions assume the host keeps host_req high until it sees host_ack, and then drops it in the cycle that follows. Under that assumption, a finished access is never counted twice. The assertions also assume mem_rdy is a clean synchronous level. The bench raises each request on a falling edge and lowers it in the same falling-edge window where the acknowledge is seen. The bench changes cfg_word either between accesses or, in the one test that targets R9, partway through an access. It drives device read data only on falling edges, so the strobe-phase capture point is never racing the data.

// File: rtl/amem_seq_pkg.sv
package amem_seq_pkg;

    localparam int CFG_W  = 32;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;
    localparam int SEL_W  = 2;

    // Packed view of the timing word, most significant field first.
    typedef struct packed {
        logic       xstb;     // [31] unsupported strobe-select mode
        logic       xwait;    // [30] unsupported extended-wait mode
        logic [3:0] wr_su;    // [29:26]
        logic [5:0] wr_sb;    // [25:20]
        logic [2:0] wr_hd;    // [19:17]
        logic [3:0] rd_su;    // [16:13]
        logic [5:0] rd_sb;    // [12:7]
        logic [2:0] rd_hd;    // [6:4]
        logic [1:0] turn;     // [3:2]
        logic [1:0] bsz;      // [1:0] 0 = 8-bit
    } tim_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic logic cfg_usable(input tim_t t);
        return !t.xstb && !t.xwait && (t.bsz == 2'd0);
    endfunction

    function automatic cnt_t setup_len(input tim_t t, input logic wr);
        return wr ? cnt_t'(t.wr_su) : cnt_t'(t.rd_su);
    endfunction

    function automatic cnt_t strobe_len(input tim_t t, input logic wr);
        return wr ? cnt_t'(t.wr_sb) : cnt_t'(t.rd_sb);
    endfunction

    function automatic cnt_t hold_len(input tim_t t, input logic wr);
        return wr ? cnt_t'(t.wr_hd) : cnt_t'(t.rd_hd);
    endfunction

endpackage

// File: rtl/amem_phase_ctr.sv
module amem_phase_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/amem_pin_drive.sv
module amem_pin_drive
    import amem_seq_pkg::*;
(
    input  phase_e              phase,
    input  logic                wr,
    input  logic [SEL_W-1:0]    sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic                cs_n,
    output logic                re_n,
    output logic                we_n,
    output logic                cle,
    output logic                ale,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe
);
    logic active;
    logic strobing;

    always_comb begin
        active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobing = (phase == PH_STROBE);
        cs_n     = !active;
        re_n     = !(strobing && !wr);
        we_n     = !(strobing && wr);
        cle      = active && sel[0];
        ale      = active && sel[1];
        dq_oe    = active && wr;
        dq_out   = (active && wr) ? wdata : '0;
    end
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_seq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] host_stat,
    input  logic [CW-1:0] cfg_word,
    output logic          mem_cs_n,
    output logic          mem_re_n,
    output logic          mem_we_n,
    output logic          mem_cle,
    output logic          mem_ale,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_rdy
);
    localparam int STAT_PAD = DW - 1;

    tim_t   tim_in;
    phase_e phase_q, phase_d;
    logic   ctr_load, ctr_done;
    cnt_t   ctr_val;
    logic   start, need_turn;

    logic            wr_q, last_wr_q, last_vld_q, ack_q;
    logic [1:0]      sel_q;
    logic [DW-1:0]   wd_q, rd_q;
    logic [DW-1:0]   stat_q;
    cnt_t            su_q, sb_q, hd_q;

    assign tim_in    = tim_t'(cfg_word);
    assign start     = host_req && !ack_q && cfg_usable(tim_in);
    assign need_turn = last_vld_q && (last_wr_q != host_wr);

    always_comb begin
        phase_d  = phase_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        case (phase_q)
            PH_IDLE: if (start) begin
                ctr_load = 1'b1;
                if (need_turn) begin
                    phase_d = PH_TURN;
                    ctr_val = cnt_t'(tim_in.turn);
                end else begin
                    phase_d = PH_SETUP;
                    ctr_val = setup_len(tim_in, host_wr);
                end
            end
            PH_TURN: if (ctr_done) begin
                phase_d  = PH_SETUP;
                ctr_load = 1'b1;
                ctr_val  = su_q;
            end
            PH_SETUP: if (ctr_done) begin
                phase_d  = PH_STROBE;
                ctr_load = 1'b1;
                ctr_val  = sb_q;
            end
            PH_STROBE: if (ctr_done) begin
                phase_d  = PH_HOLD;
                ctr_load = 1'b1;
                ctr_val  = hd_q;
            end
            PH_HOLD: if (ctr_done) begin
                phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            ack_q      <= 1'b0;
            wr_q       <= 1'b0;
            last_wr_q  <= 1'b0;
            last_vld_q <= 1'b0;
            sel_q      <= '0;
            wd_q       <= '0;
            rd_q       <= '0;
            su_q       <= '0;
            sb_q       <= '0;
            hd_q       <= '0;
        end else begin
            phase_q <= phase_d;
            ack_q   <= (phase_q == PH_HOLD) && ctr_done;
            if (phase_q == PH_IDLE && start) begin
                wr_q       <= host_wr;
                sel_q      <= host_sel;
                wd_q       <= host_wdata;
                su_q       <= setup_len(tim_in, host_wr);
                sb_q       <= strobe_len(tim_in, host_wr);
                hd_q       <= hold_len(tim_in, host_wr);
                last_wr_q  <= host_wr;
                last_vld_q <= 1'b1;
            end
            if (phase_q == PH_STROBE && ctr_done && !wr_q) begin
                rd_q <= mem_dq_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= {{STAT_PAD{1'b0}}, mem_rdy};
    end

    amem_phase_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_val),
        .done     (ctr_done)
    );

    amem_pin_drive u_pins (
        .phase  (phase_q),
        .wr     (wr_q),
        .sel    (sel_q),
        .wdata  (wd_q),
        .cs_n   (mem_cs_n),
        .re_n   (mem_re_n),
        .we_n   (mem_we_n),
        .cle    (mem_cle),
        .ale    (mem_ale),
        .dq_out (mem_dq_out),
        .dq_oe  (mem_dq_oe)
    );

    assign host_ack   = ack_q;
    assign host_rdata = rd_q;
    assign host_stat  = stat_q;
endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          host_ack,
    input logic [DW-1:0] host_stat,
    input logic          mem_cs_n,
    input logic          mem_re_n,
    input logic          mem_we_n,
    input logic          mem_cle,
    input logic          mem_ale,
    input logic          mem_dq_oe,
    input logic          mem_rdy
);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_re_n && !mem_we_n));

    // R2
    wr_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R3
    rd_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_re_n |-> !mem_cs_n);

    // R5
    latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (!mem_cle && !mem_ale));

    // R6
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_re_n |-> !mem_dq_oe);

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R8
    ack_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> mem_cs_n);

    // R10
    stat_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (host_stat[0] == $past(mem_rdy)));

    // R10
    stat_pad_chk: assert property (@(posedge clk) disable iff (rst)
        host_stat[DW-1:1] == '0);
endmodule

bind amem_strobe_seq amem_strobe_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_ack  (host_ack),
    .host_stat (host_stat),
    .mem_cs_n  (mem_cs_n),
    .mem_re_n  (mem_re_n),
    .mem_we_n  (mem_we_n),
    .mem_cle   (mem_cle),
    .mem_ale   (mem_ale),
    .mem_dq_oe (mem_dq_oe),
    .mem_rdy   (mem_rdy)
);

// File: tb/amem_strobe_seq_bench.sv
module amem_strobe_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [1:0]  h_sel = 2'b00;
    logic [7:0]  h_wd = 8'h00;
    logic        h_ack;
    logic [7:0]  h_rd, h_stat;
    logic [31:0] cfg = 32'h0;
    logic        cs_n, re_n, we_n, cle, ale, oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'hEE;
    logic        rdy = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    amem_strobe_seq u_amem_strobe_seq (
        .clk(clk), .rst(rst),
        .host_req(h_req), .host_wr(h_wr), .host_sel(h_sel), .host_wdata(h_wd),
        .host_ack(h_ack), .host_rdata(h_rd), .host_stat(h_stat),
        .cfg_word(cfg),
        .mem_cs_n(cs_n), .mem_re_n(re_n), .mem_we_n(we_n),
        .mem_cle(cle), .mem_ale(ale), .mem_dq_out(dq_out), .mem_dq_oe(oe),
        .mem_dq_in(dq_in), .mem_rdy(rdy)
    );

    function automatic logic [31:0] mk(int ws, int wsb, int wh, int rs, int rsb, int rh, int ta);
        logic [31:0] c;
        c = '0;
        c[29:26] = ws[3:0];  c[25:20] = wsb[5:0]; c[19:17] = wh[2:0];
        c[16:13] = rs[3:0];  c[12:7]  = rsb[5:0]; c[6:4]   = rh[2:0];
        c[3:2]   = ta[1:0];
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One access; measures phases at falling edges.
    task automatic run_acc(input logic w, input logic [1:0] s, input logic [7:0] d,
                           input bit chg, input logic [31:0] mcfg,
                           output int pre, output int su, output int sb, output int hd,
                           output logic [7:0] rd, output bit pin_ok,
                           output bit ack_cs, output bit ack_one);
        int n;
        int idx;
        bit seen_cs, seen_sb, slow;
        pre = 0; su = 0; sb = 0; hd = 0; n = 0; idx = 0;
        seen_cs = 0; seen_sb = 0; pin_ok = 1; ack_cs = 0; ack_one = 0;
        @(negedge clk);
        h_wr = w; h_sel = s; h_wd = d; h_req = 1'b1;
        while (1) begin
            @(negedge clk);
            n++;
            if (chg && n == 2) cfg = mcfg;
            if (h_ack) begin
                ack_cs = cs_n;
                break;
            end
            if (n > 600) begin
                chk(0, "R8 ack timeout", n, 600);
                break;
            end
            slow = w ? !we_n : !re_n;
            if (w ? !re_n : !we_n) pin_ok = 0;
            if (cs_n) begin
                if (!seen_cs) pre++;
                if (cle || ale || oe) pin_ok = 0;
            end else begin
                seen_cs = 1;
                if (cle != s[0] || ale != s[1]) pin_ok = 0;
                if (oe != w) pin_ok = 0;
                if (w && dq_out != d) pin_ok = 0;
                if (slow) begin
                    sb++; seen_sb = 1;
                    if (!w) begin dq_in = 8'h40 + 8'(idx); idx++; end
                end else begin
                    if (!w) dq_in = 8'hEE;
                    if (seen_sb) hd++; else su++;
                end
            end
        end
        rd = h_rd;
        h_req = 1'b0;
        @(negedge clk);
        ack_one = !h_ack;
    endtask

    task automatic expect_acc(input string name, input logic w, input logic [1:0] s,
                              input logic [7:0] d, input int epre, input int esu,
                              input int esb, input int ehd,
                              input bit chg, input logic [31:0] mcfg);
        int pre, su, sb, hd;
        logic [7:0] rd;
        bit pin_ok, ack_cs, ack_one;
        string rq;
        rq = w ? "R2" : "R3";
        run_acc(w, s, d, chg, mcfg, pre, su, sb, hd, rd, pin_ok, ack_cs, ack_one);
        chk(pre == epre, {"R4 turnaround gap ", name}, pre, epre);
        chk(su == esu, {rq, " setup ", name}, su, esu);
        chk(sb == esb, {rq, " strobe ", name}, sb, esb);
        chk(hd == ehd, {rq, " hold ", name}, hd, ehd);
        chk(pin_ok, {"R5 R6 latch/drive pins ", name}, int'(pin_ok), 1);
        chk(ack_cs && ack_one, {"R8 ack pulse ", name}, int'(ack_cs && ack_one), 1);
        if (!w) chk(rd == 8'h40 + 8'(esb - 1), {"R7 read capture ", name}, int'(rd), 'h40 + esb - 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cs_n && re_n && we_n, "R1 strobes high in reset", int'({cs_n, re_n, we_n}), 7);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(cs_n && re_n && we_n, "R1 strobes high after reset", int'({cs_n, re_n, we_n}), 7);
        chk(!h_ack && !cle && !ale && !oe, "R1 ack/latch/oe low", int'({h_ack, cle, ale, oe}), 0);
    endtask

    task automatic t_basic();
        cfg = mk(1, 3, 1, 1, 5, 1, 3);
        expect_acc("first write", 1'b1, 2'b01, 8'hA5, 0, 2, 4, 2, 0, '0);
        expect_acc("read after write", 1'b0, 2'b00, 8'h00, 4, 2, 6, 2, 0, '0);
        expect_acc("read same dir", 1'b0, 2'b10, 8'h00, 0, 2, 6, 2, 0, '0);
        expect_acc("write after read", 1'b1, 2'b11, 8'h3C, 4, 2, 4, 2, 0, '0);
    endtask

    task automatic t_zero();
        cfg = mk(0, 0, 0, 0, 0, 0, 0);
        expect_acc("min write", 1'b1, 2'b10, 8'h81, 0, 1, 1, 1, 0, '0);
        expect_acc("min read", 1'b0, 2'b01, 8'h00, 1, 1, 1, 1, 0, '0);
    endtask

    task automatic t_max();
        cfg = mk(15, 63, 7, 15, 63, 7, 3);
        expect_acc("max write", 1'b1, 2'b00, 8'hFF, 4, 16, 64, 8, 0, '0);
        expect_acc("max read", 1'b0, 2'b00, 8'h00, 4, 16, 64, 8, 0, '0);
    endtask

    task automatic t_cfg_change();
        cfg = mk(2, 4, 3, 1, 2, 1, 2);
        expect_acc("R9 cfg changed mid-write", 1'b1, 2'b01, 8'h5A, 3, 3, 5, 4, 1, mk(0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_reject();
        int act;
        act = 0;
        cfg = mk(0, 1, 0, 0, 1, 0, 0) | 32'h0000_0001;
        @(negedge clk);
        h_wr = 1'b1; h_sel = 2'b01; h_wd = 8'h11; h_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!cs_n || !we_n || !re_n || h_ack) act++;
        end
        h_req = 1'b0;
        chk(act == 0, "R11 bus-size nonzero blocks access", act, 0);
        cfg = mk(0, 1, 0, 0, 1, 0, 0) | 32'h4000_0000;
        act = 0;
        h_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!cs_n || !we_n || !re_n || h_ack) act++;
        end
        h_req = 1'b0;
        chk(act == 0, "R11 mode bit 30 blocks access", act, 0);
        cfg = mk(0, 1, 0, 0, 1, 0, 0);
        expect_acc("R11 after fix", 1'b1, 2'b01, 8'h11, 0, 1, 2, 1, 0, '0);
    endtask

    task automatic t_status();
        @(negedge clk); rdy = 1'b1;
        @(negedge clk);
        chk(h_stat == 8'h01, "R10 ready high", int'(h_stat), 1);
        rdy = 1'b0;
        @(negedge clk);
        chk(h_stat == 8'h00, "R10 ready low", int'(h_stat), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_zero();
        t_max();
        t_cfg_change();
        t_reject();
        t_status();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule